// File: doc/BRIEF.md
# Ping-Pong Dual-Bank Stream Buffer

The block takes an unbroken stream of words, one per accepted input beat, and files them alternately into two banks of equal depth `N`. The first `N` words go to bank 0, the next `N` to bank 1, then bank 0 again, and so on. The input is never back-pressured. There is no ready signal, and every beat with `in_valid` high is stored.

Each bank drains through its own output port at half the input word rate. A bank's read walk starts at address 0 on the beat that writes its middle word (address `N/2`). After that, the port reads one word on every second accepted input beat. The walk therefore stretches over two buffering periods. It overlaps the filling of the other bank and the first half of its own next fill, and it never falls behind the overwrite.

The two ports feed two parallel downstream paths. Each output word carries a tag giving which fill of its bank it came from. Total storage is `2N` words.

Top module: `pp_stream_buf`

## Requirements
- R1: While reset is low and in the cycle after it, both output valids are 0 and both tags and data are 0. After a reset, the first word on each port carries tag 0.
- R2: Accepted input words are counted from reset with index j. Word j is stored in bank (j/N) mod 2. Port 0 only ever emits words from even periods, and port 1 only words from odd periods.
- R3: Read r of port b (r counted from 0 since reset) outputs data word index (2*(r/N)+b)*N + (r mod N). Its tag is (r/N) mod 2^TAGW. Addresses are read in ascending order.
- R4: Port b reads address 0 of fill k on the accepted beat with index (2k+b)*N + N/2, which is the beat writing address N/2 of that fill. The output valid rises in the clock cycle after that beat.
- R5: Port b performs read r on accepted beat index b*N + N/2 + 2r, one read every second accepted beat. The schedule runs with no pause between fills. When both ports are active they read on the same beats.
- R6: Port 0 emits nothing until N/2+1 words have been accepted after reset. Port 1 emits nothing until 3N/2+1 words have been accepted.
- R7: A cycle with in_valid low advances no pointer, and neither output valid is high in the following cycle.
- R8: After B accepted beats, port b has emitted exactly max(0, ceil((B - b*N - N/2)/2)) words. None is lost or duplicated.
- R9: An output valid never stays high for two consecutive cycles.
- R10: Tags wrap modulo 2^TAGW. Fill 2^TAGW of a bank is tagged 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | W | Input word |
| out0_valid | output | 1 | Port 0 word valid (one-cycle pulse) |
| out0_data | output | W | Port 0 word, drained from bank 0 |
| out0_tag | output | TAGW | Fill number of bank 0 for this word |
| out1_valid | output | 1 | Port 1 word valid (one-cycle pulse) |
| out1_data | output | W | Port 1 word, drained from bank 1 |
| out1_tag | output | TAGW | Fill number of bank 1 for this word |

## Verification
Some properties are checked by assertions on every cycle:
- idle input gives no output the next cycle;
- each valid is a single-cycle pulse;
- port 1 never fires without port 0;
- neither port fires before its half-bank threshold;
- each read walk restarts at address 0 exactly when the midpoint write happens.

Other properties can only be shown by the bench's scenarios, which stream an incrementing counter through irregular bursts and gaps. These are the content and ordering of every word, the exact beat on which each read happens, the per-port word counts, and tag wrap-around after many fills.

// File: rtl/pp_stream_buf.sv
module pp_stream_buf #(
  parameter int N    = 8,
  parameter int W    = 16,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    in_data,
  output logic            out0_valid,
  output logic [W-1:0]    out0_data,
  output logic [TAGW-1:0] out0_tag,
  output logic            out1_valid,
  output logic [W-1:0]    out1_data,
  output logic [TAGW-1:0] out1_tag
);
  localparam int AW = $clog2(N);
  localparam logic [AW-1:0] HALF = AW'(N / 2);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [W-1:0]  mem [2][N];
  logic          wr_bank;
  logic [AW-1:0] wr_addr;

  logic [1:0]            start, go, ov;
  logic [1:0][AW-1:0]    rd_addr;
  logic [1:0][W-1:0]     od;
  logic [1:0][TAGW-1:0]  ot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_addr <= '0;
      wr_bank <= 1'b0;
    end else if (in_valid) begin
      wr_addr <= wr_addr + 1'b1;
      if (wr_addr == LAST) wr_bank <= ~wr_bank;
    end

  always_ff @(posedge clk)
    if (in_valid) mem[wr_bank][wr_addr] <= in_data;

  for (genvar g = 0; g < 2; g++) begin : g_port
    logic            active, skip, vld;
    logic [AW-1:0]   addr;
    logic [TAGW-1:0] fill, tag;
    logic [W-1:0]    dat;

    assign start[g]   = in_valid && (wr_bank == 1'(g)) && (wr_addr == HALF);
    assign go[g]      = in_valid && (start[g] || (active && !skip));
    assign rd_addr[g] = addr;
    assign ov[g]      = vld;
    assign od[g]      = dat;
    assign ot[g]      = tag;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        active <= 1'b0;
        skip   <= 1'b0;
        vld    <= 1'b0;
        addr   <= '0;
        fill   <= '0;
        tag    <= '0;
        dat    <= '0;
      end else begin
        vld <= go[g];
        if (start[g]) active <= 1'b1;
        if (in_valid) skip <= go[g];
        if (go[g]) begin
          dat  <= mem[g][addr];
          tag  <= fill;
          addr <= addr + 1'b1;
          if (addr == LAST) fill <= fill + 1'b1;
        end
      end
  end

  assign out0_valid = ov[0];
  assign out0_data  = od[0];
  assign out0_tag   = ot[0];
  assign out1_valid = ov[1];
  assign out1_data  = od[1];
  assign out1_tag   = ot[1];
endmodule

// File: rtl/pp_stream_buf_chk.sv
module pp_stream_buf_chk #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               v0,
  input logic               v1,
  input logic [1:0]         start,
  input logic [1:0][AW-1:0] rd_addr
);
  int beats;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) beats <= 0;
    else if (in_valid && beats < 2 * N) beats <= beats + 1;

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!v0 && !v1));
  a_r9_pulse0: assert property (@(posedge clk) disable iff (!rst_n)
    v0 |=> !v0);
  a_r9_pulse1: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> !v1);
  a_r5_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> v0);
  a_r6_early0: assert property (@(posedge clk) disable iff (!rst_n)
    v0 |-> beats > N / 2);
  a_r6_early1: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> beats > N + N / 2);
  a_r4_start0: assert property (@(posedge clk) disable iff (!rst_n)
    start[0] |-> rd_addr[0] == '0);
  a_r4_start1: assert property (@(posedge clk) disable iff (!rst_n)
    start[1] |-> rd_addr[1] == '0);
endmodule

bind pp_stream_buf pp_stream_buf_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .v0(out0_valid), .v1(out1_valid), .start(start), .rd_addr(rd_addr)
);

// File: tb/tb_pp_stream_buf.sv
module tb_pp_stream_buf;
  localparam int N = 8, W = 16, TAGW = 4;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic out0_valid, out1_valid;
  logic [W-1:0] out0_data, out1_data;
  logic [TAGW-1:0] out0_tag, out1_tag;

  pp_stream_buf #(.N(N), .W(W), .TAGW(TAGW)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, beats = 0;
  int cnt [2];
  bit last_ov [2];
  bit prev_v = 0;

  localparam logic [15:0] VEC [0:11] = '{
    {8'd4, 8'd1}, {8'd1, 8'd1}, {8'd2, 8'd3}, {8'd5, 8'd0},
    {8'd7, 8'd2}, {8'd1, 8'd0}, {8'd3, 8'd1}, {8'd8, 8'd4},
    {8'd2, 8'd1}, {8'd6, 8'd0}, {8'd9, 8'd2}, {8'd4, 8'd3}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int b_beats, input int b);
    int s = b * N + N / 2;
    return (b_beats > s) ? (b_beats - s + 1) / 2 : 0;
  endfunction

  task automatic step(input bit v);
    @(negedge clk);
    if (prev_v) beats++;
    for (int b = 0; b < 2; b++) begin
      bit ov = b ? out1_valid : out0_valid;
      int d  = b ? int'(out1_data) : int'(out0_data);
      int t  = b ? int'(out1_tag) : int'(out0_tag);
      if (!prev_v) chk(!ov, "R7 idle", int'(ov), 0);
      if (ov) begin
        int r = cnt[b], k = cnt[b] / N, a = cnt[b] % N;
        chk(d == (2 * k + b) * N + a, "R3 data", d, (2 * k + b) * N + a);
        chk(((d / N) % 2) == b, "R2 bank", (d / N) % 2, b);
        if (k >= (1 << TAGW)) chk(t == k % (1 << TAGW), "R10 tag wrap", t, k % (1 << TAGW));
        else chk(t == k, "R3 tag", t, k);
        if (a == 0) chk(beats == (2 * k + b) * N + N / 2 + 1, "R4 start beat", beats, (2 * k + b) * N + N / 2 + 1);
        else chk(beats == b * N + N / 2 + 2 * r + 1, "R5 read beat", beats, b * N + N / 2 + 2 * r + 1);
        chk(!last_ov[b], "R9 pulse", int'(last_ov[b]), 0);
        cnt[b]++;
      end
      last_ov[b] = ov;
    end
    in_valid = v;
    in_data  = W'(beats);
    prev_v   = v;
  endtask

  task automatic count_check(input string req);
    for (int b = 0; b < 2; b++)
      chk(cnt[b] == exp_cnt(beats, b), req, cnt[b], exp_cnt(beats, b));
  endtask

  task automatic zero_check();
    chk(!out0_valid && !out1_valid, "R1 valid", int'(out0_valid) + int'(out1_valid), 0);
    chk(out0_tag == 0 && out1_tag == 0, "R1 tag", int'(out0_tag) + int'(out1_tag), 0);
    chk(out0_data == 0 && out1_data == 0, "R1 data", int'(out0_data) + int'(out1_data), 0);
  endtask

  bit done = 0;
  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cnt = '{0, 0};
    last_ov = '{0, 0};
    repeat (3) @(negedge clk);
    zero_check();
    rst_n = 1;
    @(negedge clk);
    zero_check();

    for (int i = 0; i < 12; i++) begin
      repeat (int'(VEC[i][15:8])) step(1);
      repeat (int'(VEC[i][7:0])) step(0);
      step(0);
      count_check("R8 count");
    end

    repeat (2 * N * (1 << TAGW) + 3 * N) step(1);
    step(0);
    count_check("R8 count long");
    chk(cnt[0] > N * (1 << TAGW), "R10 reached", cnt[0], N * (1 << TAGW));

    @(negedge clk);
    rst_n = 0;
    in_valid = 0;
    prev_v = 0;
    @(negedge clk);
    zero_check();
    rst_n = 1;
    beats = 0;
    cnt = '{0, 0};
    last_ov = '{0, 0};
    repeat (N / 2) step(1);
    step(0);
    chk(cnt[0] == 0, "R6 early port0", cnt[0], 0);
    repeat (N) step(1);
    step(0);
    chk(cnt[1] == 0, "R6 early port1", cnt[1], 0);
    chk(cnt[0] > 0, "R1 restart", cnt[0], 1);
    repeat (3 * N) step(1);
    step(0);
    count_check("R8 count after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule